// File: doc/BRIEF.md
# Maskable Interrupt Register with Clear-on-Read

This block holds the interrupt state of a PHY management register file in one 16-bit word. The lower byte records events: a one-cycle pulse on any of eight event inputs sets a matching sticky status bit. The upper byte holds one mask bit per event. When a status bit and its mask bit are both 1, the block drives a single interrupt pin to its active level.

A read strobe from the register file returns the whole word and clears every status bit on the next clock. Software can therefore collect and acknowledge all pending causes with one access. Writes change only the mask byte. The active level of the pin comes from a polarity input that another register drives. With that input at 0 the pin is active low.

The reset input is asynchronous and active low. Internally it is released synchronously, two clocks after `rst_n` rises.

Top module: `phy_irq_reg`

## Requirements
- R1: After reset, all mask bits and all status bits are 0, `rdata_o` reads 0x0000, and `irq_pin_o` rests at its inactive level.
- R2: A 1 on `evt_i[k]` at a clock edge sets status bit k (`rdata_o[k]`). The bit stays 1 until a read clears it.
- R3: `rdata_o` always shows {mask byte, status byte}. During a read strobe it therefore shows the status from before the clear. The status byte is 0 on the cycle after the strobe unless an event arrives in the strobe cycle.
- R4: An event in the same cycle as a read strobe leaves its status bit at 1 after the clear.
- R5: A write loads `wdata_i[15:8]` into the mask byte, which reads back on `rdata_o[15:8]` from the next cycle. Without a write the mask byte holds.
- R6: A write has no effect on the status byte, whatever `wdata_i[7:0]` holds.
- R7: The interrupt is pending when any bit of (mask byte AND status byte) is 1. The pin is active exactly while an interrupt is pending.
- R8: Status bits record events while their mask bit is 0. Setting the mask bit later makes the pin active on the cycle after the write.
- R9: With `pol_high_i` = 1 the active pin level is 1. With `pol_high_i` = 0 the active pin level is 0. A change of `pol_high_i` shows on the pin in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Event pulses, one per status bit |
| wr_en_i | input | 1 | Write strobe for the word |
| wdata_i | input | 16 | Write data; only bits 15:8 are used |
| rd_en_i | input | 1 | Read strobe; clears status on the next edge |
| rdata_o | output | 16 | Current word {mask, status} |
| pol_high_i | input | 1 | Pin polarity: 1 selects active high |
| irq_pin_o | output | 1 | Interrupt pin |

## Verification
The assertions assume that all inputs are known and driven from the first clock after the internal reset release. They also assume that no event, read or write is needed while the synchronizer still holds the block in reset, because inputs in that window are dropped by design.

The stimulus holds every input at 0 through reset and the synchronizer window. After that it changes inputs only just after a clock edge. Events are applied as single-cycle pulses, alone and together with reads and writes, so that every assumed input pattern is valid at each sampling edge.

// File: rtl/irq_reg_pkg.sv
package irq_reg_pkg;
  parameter int unsigned IRQ_NUM_EVT  = 8;
  parameter int unsigned RST_SYNC_LEN = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] shf_q;
  logic [STAGES-1:0] shf_d;

  always_comb shf_d = {shf_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= '0;
    else        shf_q <= shf_d;
  end

  assign rst_sync_n = shf_q[STAGES-1];
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;
  logic [N-1:0] stat_d;
  logic [N-1:0] stat_ce;

  for (genvar k = 0; k < N; k++) begin : g_bit
    // set wins over clear so a coincident event survives
    always_comb begin
      stat_ce[k] = evt_i[k] | clr_i;
      stat_d[k]  = (stat_q[k] & ~clr_i) | evt_i[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_q[k] <= 1'b0;
      else if (stat_ce[k]) stat_q[k] <= stat_d[k];
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;
  logic [N-1:0] en_d;

  always_comb en_d = wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= '0;
    else if (wr_en_i) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] stat_i,
  input  logic         pol_high_i,
  output logic         pin_o
);
  logic pending;

  always_comb begin
    pending = |(en_i & stat_i);
    pin_o   = pol_high_i ? pending : ~pending;
  end
endmodule

// File: rtl/phy_irq_reg.sv
module phy_irq_reg #(
  parameter int unsigned NUM_EVT = irq_reg_pkg::IRQ_NUM_EVT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EVT-1:0]   evt_i,
  input  logic                 wr_en_i,
  input  logic [2*NUM_EVT-1:0] wdata_i,
  input  logic                 rd_en_i,
  output logic [2*NUM_EVT-1:0] rdata_o,
  input  logic                 pol_high_i,
  output logic                 irq_pin_o
);
  localparam int unsigned WORD_W = 2 * NUM_EVT;
  localparam int unsigned MSK_LO = NUM_EVT;

  logic               rst_sync_n;
  logic [NUM_EVT-1:0] stat_q;
  logic [NUM_EVT-1:0] msk_q;

  irq_rst_sync #(.STAGES(irq_reg_pkg::RST_SYNC_LEN)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_status_bank #(.N(NUM_EVT)) u_stat (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt_i  (evt_i),
    .clr_i  (rd_en_i),
    .stat_o (stat_q)
  );

  irq_enable_reg #(.N(NUM_EVT)) u_msk (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i[WORD_W-1:MSK_LO]),
    .en_o    (msk_q)
  );

  irq_pin_drive #(.N(NUM_EVT)) u_pin (
    .en_i       (msk_q),
    .stat_i     (stat_q),
    .pol_high_i (pol_high_i),
    .pin_o      (irq_pin_o)
  );

  assign rdata_o = {msk_q, stat_q};
endmodule

// File: rtl/phy_irq_reg_chk.sv
module phy_irq_reg_chk #(
  parameter int unsigned NUM_EVT = 8
) (
  input logic                 clk,
  input logic                 rst_ok_n,
  input logic [NUM_EVT-1:0]   evt_i,
  input logic                 wr_en_i,
  input logic [2*NUM_EVT-1:0] wdata_i,
  input logic                 rd_en_i,
  input logic [2*NUM_EVT-1:0] rdata_o,
  input logic                 pol_high_i,
  input logic                 irq_pin_o
);
  localparam int unsigned W = 2 * NUM_EVT;

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !rd_en_i |=> ((rdata_o[NUM_EVT-1:0] & $past(rdata_o[NUM_EVT-1:0]))
                  == $past(rdata_o[NUM_EVT-1:0])));

  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_ok_n)
    1'b1 |=> ((rdata_o[NUM_EVT-1:0] & $past(evt_i)) == $past(evt_i)));

  // covers R4 too: only the strobe-cycle events remain after the clear
  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_ok_n)
    rd_en_i |=> (rdata_o[NUM_EVT-1:0] == $past(evt_i)));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    wr_en_i |=> (rdata_o[W-1:NUM_EVT] == $past(wdata_i[W-1:NUM_EVT])));

  assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !wr_en_i |=> $stable(rdata_o[W-1:NUM_EVT]));

  assert_write_no_status_R6: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (wr_en_i && !rd_en_i && evt_i == '0) |=> $stable(rdata_o[NUM_EVT-1:0]));

  assert_pin_active_R7: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (|(rdata_o[W-1:NUM_EVT] & rdata_o[NUM_EVT-1:0])) |-> (irq_pin_o == pol_high_i));

  assert_pin_idle_R9: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !(|(rdata_o[W-1:NUM_EVT] & rdata_o[NUM_EVT-1:0])) |-> (irq_pin_o != pol_high_i));
endmodule

bind phy_irq_reg phy_irq_reg_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk        (clk),
  .rst_ok_n   (rst_sync_n),
  .evt_i      (evt_i),
  .wr_en_i    (wr_en_i),
  .wdata_i    (wdata_i),
  .rd_en_i    (rd_en_i),
  .rdata_o    (rdata_o),
  .pol_high_i (pol_high_i),
  .irq_pin_o  (irq_pin_o)
);

// File: tb/sim_phy_irq_reg.sv
module sim_phy_irq_reg;
  logic        clk;
  logic        rst_n;
  logic [7:0]  evt_i;
  logic        wr_en_i;
  logic [15:0] wdata_i;
  logic        rd_en_i;
  logic [15:0] rdata_o;
  logic        pol_high_i;
  logic        irq_pin_o;

  phy_irq_reg u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .rd_en_i    (rd_en_i),
    .rdata_o    (rdata_o),
    .pol_high_i (pol_high_i),
    .irq_pin_o  (irq_pin_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef struct {
    string       tag;
    logic [15:0] word;
    logic        pin;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  logic [7:0] m_msk;
  logic [7:0] m_st;
  logic       m_pol;

  function automatic logic exp_pin(logic [7:0] msk, logic [7:0] st, logic pol);
    logic pend;
    pend = |(msk & st);
    return pol ? pend : ~pend;
  endfunction

  // push what the outputs must show now, then drive one cycle and advance the model
  task automatic step(input logic [7:0] ev, input logic wr, input logic [15:0] wd,
                      input logic rd, input logic pol, input string tag);
    exp_t e;
    m_pol  = pol;
    pol_high_i = pol;
    #0;
    e.tag  = tag;
    e.word = {m_msk, m_st};
    e.pin  = exp_pin(m_msk, m_st, m_pol);
    exp_q.push_back(e);
    evt_i   = ev;
    wr_en_i = wr;
    wdata_i = wd;
    rd_en_i = rd;
    @(posedge clk);
    #1;
    m_st = (rd ? 8'h00 : m_st) | ev;
    if (wr) m_msk = wd[15:8];
    evt_i   = '0;
    wr_en_i = 1'b0;
    wdata_i = '0;
    rd_en_i = 1'b0;
  endtask

  // monitor: compare queued expectations at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if (rdata_o !== e.word || irq_pin_o !== e.pin) begin
        n_fail++;
        $display("FAIL %s: rdata=%h pin=%b expected rdata=%h pin=%b",
                 e.tag, rdata_o, irq_pin_o, e.word, e.pin);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt_i = '0; wr_en_i = 1'b0; wdata_i = '0; rd_en_i = 1'b0;
    pol_high_i = 1'b0;
    m_msk = '0; m_st = '0; m_pol = 1'b0;
    #11 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, pin inactive (high when active low)
    step(8'h00, 0, 16'h0000, 0, 0, "R1");
    // R2: events set sticky bits with mask 0, pin idle (R8 recording)
    step(8'h05, 0, 16'h0000, 0, 0, "R2");
    step(8'h00, 0, 16'h0000, 0, 0, "R2");
    step(8'h00, 0, 16'h0000, 0, 0, "R8");
    step(8'h10, 0, 16'h0000, 0, 0, "R2");
    // R5 and R6: write mask A3 with status byte 00 in data
    step(8'h00, 1, 16'hA300, 0, 0, "R5");
    // R8 and R7: pin active next cycle after enabling
    step(8'h00, 0, 16'h0000, 0, 0, "R8");
    // R6: write with FF in low byte leaves status alone
    step(8'h00, 1, 16'h02FF, 0, 0, "R6");
    step(8'h00, 0, 16'h0000, 0, 0, "R6");
    // R7: mask 02 against status 15: no overlap, pin idle
    step(8'h00, 0, 16'h0000, 0, 0, "R7");
    step(8'h02, 0, 16'h0000, 0, 0, "R7");
    // R9: polarity flip shows the same cycle
    step(8'h00, 0, 16'h0000, 0, 1, "R9");
    step(8'h00, 0, 16'h0000, 0, 0, "R9");
    step(8'h00, 0, 16'h0000, 0, 1, "R9");
    // R3: read shows pre-clear word, status 0 afterwards
    step(8'h00, 0, 16'h0000, 1, 1, "R3");
    step(8'h00, 0, 16'h0000, 0, 1, "R3");
    // R4: event coincident with read survives
    step(8'h40, 0, 16'h0000, 0, 1, "R4");
    step(8'h82, 0, 16'h0000, 1, 1, "R4");
    step(8'h00, 0, 16'h0000, 0, 1, "R4");
    // R3: back-to-back reads, second sees cleared value
    step(8'h00, 0, 16'h0000, 1, 0, "R3");
    step(8'h00, 0, 16'h0000, 1, 0, "R3");
    // R5: write and read in one cycle, mask loads and status clears
    step(8'h08, 0, 16'h0000, 0, 0, "R5");
    step(8'h00, 1, 16'hFF00, 1, 0, "R5");
    step(8'h00, 0, 16'h0000, 0, 0, "R5");
    // R7: each event alone with full mask
    for (int k = 0; k < 8; k++) begin
      step(8'(1 << k), 0, 16'h0000, 0, 0, "R7");
      step(8'h00, 0, 16'h0000, 1, 0, "R7");
    end
    step(8'h00, 0, 16'h0000, 0, 0, "R7");
    // R5: mask cleared, then status pending but pin idle
    step(8'h00, 1, 16'h0000, 0, 1, "R5");
    step(8'hFF, 0, 16'h0000, 0, 1, "R8");
    step(8'h00, 1, 16'h8000, 0, 1, "R8");
    step(8'h00, 0, 16'h0000, 0, 1, "R8");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule